// File: doc/BRIEF.md
# External Bus Byte-Strobe Generator

This block produces the write strobes and byte-lane signals for one external write cycle. The cycle has two bus states, T1 and T2. Each bus state lasts two clock cycles, a first half and a second half. A request names the space width (8-bit or 16-bit), the access size (byte or word) and address bit 0. The block samples it together with a lane-scheme select bit taken from the bus control register.

Three shared active-low pins carry the result. In the split-strobe scheme (select = 0) they carry an upper-byte write strobe, a lower-byte write strobe and A0. In the common-strobe scheme (select = 1) they carry one common write strobe and two byte enables. An access to 8-bit space always uses A0 plus a plain write strobe, whatever the select bit says. A busy flag covers the cycle. A one-clock done pulse marks the release of the strobes.

Top module: `xbus_byte_strobe`

## Requirements
- R1: After reset and whenever busy is 0, pin_a, pin_b and pin_c are all 1 and busy is 0. done is 0 after reset.
- R2: A request is accepted on a clock edge where req_valid is 1 and busy is 0. busy is then 1 for exactly four clocks: T1 first half, T1 second half, T2 first half, T2 second half. After that, busy returns to 0.
- R3: In 8-bit space, and in 16-bit space with select = 0, pin_a equals the sampled address bit 0 for all four busy clocks.
- R4: With 16-bit space and select = 0: pin_b is the upper write strobe and pin_c is the lower write strobe. Each is 0 in T1 second half, T2 first half and T2 second half when its lane is selected, and 1 otherwise. No strobe is 0 in T1 first half.
- R5: With 16-bit space and select = 1: pin_c is a common write strobe that is 0 in the last three busy clocks. pin_a is the upper-byte enable and pin_b is the lower-byte enable. Each enable is 0 for all four busy clocks when its lane is selected.
- R6: Lane selection applies in 16-bit space. A word access (req_word = 1) selects both lanes. A byte access with address bit 0 = 0 selects the upper lane; with address bit 0 = 1 it selects the lower lane.
- R7: In 8-bit space (req_wide = 0), the select bit and req_word have no effect. pin_c is a write strobe, 0 in the last three busy clocks. pin_b stays 1. pin_a carries address bit 0.
- R8: The select bit and the request fields are sampled only when the request is accepted. Changes to them during a cycle have no effect on the pins.
- R9: done is 1 for exactly the one clock after T2 second half. In that clock, busy is 0 and all pins are 1. A request held while busy is accepted at the end of that clock, so the next cycle starts on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each bus state spans two clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_a0 | input | 1 | Address bit 0 of the request |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_wide | input | 1 | 1 = 16-bit space, 0 = 8-bit space |
| sel_bytelane | input | 1 | Lane scheme: 0 = split strobes with A0, 1 = common strobe with byte enables |
| pin_a | output | 1 | A0, or upper-byte enable (active low) |
| pin_b | output | 1 | Upper write strobe, or lower-byte enable (active low) |
| pin_c | output | 1 | Lower write strobe, or common write strobe (active low) |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | One-clock pulse after the cycle ends |

## Verification
A phase register stuck or skipping a state shows at once at the ports. The busy window comes out shorter or longer than four clocks, and a strobe is wrong in a first half, both visible within the same cycle. A wrongly latched field shows on the first busy clock through pin_a in the enable scheme. In the other schemes it shows one clock later, on the strobe pins. The bench compares every pin in every busy clock against a model for all sixteen combinations of select, width, size and A0. It also scrambles the inputs mid-cycle, so a design that reads live inputs diverges from the model within one clock.

// File: rtl/xbus_byte_strobe.sv
module xbus_byte_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_a0,
  input  logic req_word,
  input  logic req_wide,
  input  logic sel_bytelane,
  output logic pin_a,
  output logic pin_b,
  output logic pin_c,
  output logic busy,
  output logic done
);

  typedef enum logic [2:0] {PH_IDLE, PH_T1A, PH_T1B, PH_T2A, PH_T2B} phase_t;

  phase_t ph;
  logic   a0_q, word_q, wide_q, sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      a0_q   <= 1'b0;
      word_q <= 1'b0;
      wide_q <= 1'b0;
      sel_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= (ph == PH_T2B);
      unique case (ph)
        PH_IDLE: if (req_valid) begin
          ph     <= PH_T1A;
          a0_q   <= req_a0;
          word_q <= req_word;
          wide_q <= req_wide;
          sel_q  <= sel_bytelane;
        end
        PH_T1A:  ph <= PH_T1B;
        PH_T1B:  ph <= PH_T2A;
        PH_T2A:  ph <= PH_T2B;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  logic act, stb, hi_ln, lo_ln;
  assign act   = (ph != PH_IDLE);
  assign stb   = act && (ph != PH_T1A);
  assign hi_ln = word_q | ~a0_q;
  assign lo_ln = word_q |  a0_q;
  assign busy  = act;

  always_comb begin
    if (!act) begin
      {pin_a, pin_b, pin_c} = 3'b111;
    end else if (!wide_q) begin
      {pin_a, pin_b, pin_c} = {a0_q, 1'b1, ~stb};
    end else if (!sel_q) begin
      {pin_a, pin_b, pin_c} = {a0_q, ~(stb & hi_ln), ~(stb & lo_ln)};
    end else begin
      {pin_a, pin_b, pin_c} = {~hi_ln, ~lo_ln, ~stb};
    end
  end

endmodule

// File: rtl/xbus_byte_strobe_chk.sv
module xbus_byte_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_wide,
  input logic pin_a,
  input logic pin_b,
  input logic pin_c,
  input logic busy,
  input logic done
);

  logic cap_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cap_wide <= 1'b0;
    else if (req_valid && !busy) cap_wide <= req_wide;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pin_a && pin_b && pin_c));

  assert_cycle_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 busy ##1 !busy);

  assert_no_early_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> pin_c);

  assert_narrow_pinb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cap_wide) |-> pin_b);

  assert_pin_a_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pin_a));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && pin_b && pin_c));

endmodule

bind xbus_byte_strobe xbus_byte_strobe_chk u_chk (.*);

// File: tb/xbus_byte_strobe_tb.sv
`timescale 1ns/1ps
module xbus_byte_strobe_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_a0 = 1'b0, req_word = 1'b0, req_wide = 1'b0, sel_bytelane = 1'b0;
  logic pin_a, pin_b, pin_c, busy, done;
  int   total = 0;
  int   bad = 0;

  always #5 clk = ~clk;

  xbus_byte_strobe u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_a0(req_a0),
    .req_word(req_word), .req_wide(req_wide), .sel_bytelane(sel_bytelane),
    .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c), .busy(busy), .done(done));

  function automatic logic [2:0] model(logic sel, logic wide, logic word, logic a0, int ph);
    logic stb, hi, lo;
    stb = (ph >= 1);
    hi  = word | ~a0;
    lo  = word | a0;
    if (ph < 0)    return 3'b111;
    if (!wide)     return {a0, 1'b1, ~stb};
    if (!sel)      return {a0, ~(stb & hi), ~(stb & lo)};
    return {~hi, ~lo, ~stb};
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {a,b,c,busy,done} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1 reset", {pin_a, pin_b, pin_c, busy, done}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", {pin_a, pin_b, pin_c, busy, done}, 5'b11100);
  endtask

  task automatic test_combo(logic sel, logic wide, logic word, logic a0);
    string tag;
    tag = !wide ? "R7 narrow" : (!sel ? "R4 R6 split" : "R5 R6 common");
    req_valid = 1'b1; sel_bytelane = sel; req_wide = wide; req_word = word; req_a0 = a0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int ph = 0; ph < 4; ph++) begin
      check(ph == 0 ? "R3 R2 first half" : tag, {pin_a, pin_b, pin_c, busy, done},
            {model(sel, wide, word, a0, ph), 2'b10});
      if (ph == 0) begin
        sel_bytelane = ~sel; req_wide = ~wide; req_word = ~word; req_a0 = ~a0;
      end
      @(negedge clk);
    end
    check("R9 done", {pin_a, pin_b, pin_c, busy, done}, 5'b11101);
    @(negedge clk);
    check("R1 R9 quiet", {pin_a, pin_b, pin_c, busy, done}, 5'b11100);
  endtask

  task automatic test_held_request();
    req_valid = 1'b1; sel_bytelane = 1'b1; req_wide = 1'b1; req_word = 1'b0; req_a0 = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      check("R2 held busy", {busy, done}, 2'b10);
      @(negedge clk);
    end
    check("R9 held done", {busy, done}, 2'b01);
    @(negedge clk);
    check("R9 restart", {pin_a, pin_b, pin_c, busy, done}, {model(1, 1, 0, 1, 0), 2'b10});
    req_valid = 1'b0;
    for (int i = 0; i < 5; i++) @(negedge clk);
    check("R2 R8 settle", {pin_a, pin_b, pin_c, busy, done}, 5'b11100);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    for (int k = 0; k < 16; k++)
      test_combo(k[3], k[2], k[1], k[0]);
    test_held_request();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule